// File: doc/BRIEF.md
# Branch Direction Predictor with Return Stack

This block sits beside an in-order fetch unit and answers two questions about each fetched branch. The first is whether the branch will be taken. A table of two-bit saturating counters, selected by the branch's word address, gives the answer when dynamic prediction is on. When it is off, a static rule gives the answer: a branch with a backward displacement is predicted taken. The second question is where a return through the link register will go. A small stack holds call return addresses to answer it. Calls push and returns pop through dedicated controls.

Resolved branches come back on the update port. Each one moves its counter one step toward the real outcome and retires one speculative branch. The block counts granted predictions that have not yet resolved. When that count reaches three, it withholds the grant for any new lookup. A flush drops the count to zero. Counter contents and stack contents are not rolled back.

Top module: `bpred_top`

## Requirements
- R1: After reset every counter holds weakly not-taken (2'b01), so a dynamic lookup predicts not-taken. The outstanding count is zero and the return stack is empty (`ret_valid` low).
- R2: The counter is selected by bits [12:2] of the PC. Two PCs that differ only outside those bits share one counter.
- R3: Counter codes are 00 strongly not-taken, 01 not-taken, 10 taken and 11 strongly taken. The dynamic prediction is the counter's upper bit. Counters saturate at 00 and 11.
- R4: An update moves the addressed counter one step toward `up_taken`. A lookup sees the new value from the next cycle on.
- R5: When `dyn_en` is low, `lk_taken` equals `lk_backward`, whatever the counter holds.
- R6: `lk_grant` is `lk_valid` while fewer than three predictions are outstanding. Each granted lookup adds one. At three, new lookups get no grant until a branch resolves.
- R7: Each `up_valid` retires one outstanding branch, and the count never goes below zero. `flush` clears the count to zero and wins over a lookup or resolve in the same cycle.
- R8: The return stack is last-in first-out. After a push, `ret_target` shows the pushed address. A pop exposes the entry below it.
- R9: The stack holds eight entries. A push onto a full stack overwrites the oldest entry, so eight pops afterwards return the eight newest addresses.
- R10: A pop on an empty stack leaves it empty and unchanged, and `ret_valid` stays low.
- R11: A push and a pop in the same cycle replace the top entry and leave the depth unchanged. On an empty stack the pair acts as a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dyn_en | input | 1 | 1 selects the counter table, 0 selects the static rule |
| lk_valid | input | 1 | A branch is being looked up this cycle |
| lk_pc | input | 32 | PC of the branch being looked up |
| lk_backward | input | 1 | Branch displacement is negative (static hint) |
| lk_taken | output | 1 | Predicted direction |
| lk_grant | output | 1 | Lookup accepted; low means the fetch must stall |
| up_valid | input | 1 | A branch has resolved |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Resolved direction |
| flush | input | 1 | Discard all outstanding speculative branches |
| push_valid | input | 1 | Call: push a return address |
| push_addr | input | 32 | Return address to push |
| pop_valid | input | 1 | Return: pop the stack |
| ret_target | output | 32 | Predicted return target (top of stack) |
| ret_valid | output | 1 | Stack is non-empty |

## Verification
A counter that is stepped wrongly or fails to saturate shows up as a wrong `lk_taken`. The error appears on the first lookup after the faulty update, one cycle later. It can also appear only after a run of updates that pushes the counter past an edge. A wrong outstanding count appears at `lk_grant` as a grant missing or extra, either on the fourth lookup or straight after a resolve or a flush at zero. A broken stack pointer or depth changes `ret_target` or `ret_valid` on the cycle after the push or pop. Overwrite faults show up only when the stack is drained after it overflows.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // One saturating step toward the resolved direction.
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_ST) ? CTR_ST : ctr_t'(c + 2'd1);
    else       return (c == CTR_SNT) ? CTR_SNT : ctr_t'(c - 2'd1);
  endfunction

  function automatic logic ctr_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/bpred_ctr_table.sv
module bpred_ctr_table
  import bpred_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output ctr_t            rd_ctr,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic            wr_taken
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_t ctr_q [ENTRIES];
  logic [IDX_W-1:0] rd_idx, wr_idx;
  ctr_t wr_old, wr_new;

  assign rd_idx = rd_pc[IDX_W+1:2];
  assign wr_idx = wr_pc[IDX_W+1:2];
  assign rd_ctr = ctr_q[rd_idx];
  assign wr_old = ctr_q[wr_idx];
  assign wr_new = ctr_step(wr_old, wr_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WNT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_new;
    end
  end

  p_sat_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_taken && wr_old == CTR_SNT |=> ctr_q[$past(wr_idx)] == CTR_SNT);
  p_sat_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && wr_old == CTR_ST |=> ctr_q[$past(wr_idx)] == CTR_ST);
  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && wr_old != CTR_ST |=> ctr_q[$past(wr_idx)] != CTR_SNT);
endmodule

// File: rtl/bpred_ret_stack.sv
module bpred_ret_stack #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] top_data,
  output logic         top_valid
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  ent_q [DEPTH];
  logic [AW-1:0] top_q;
  logic [CW-1:0] cnt_q;
  logic          empty, full, do_push, do_pop, do_swap;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_swap = push && pop && !empty;
  assign do_push = push && !do_swap;
  assign do_pop  = pop && !push && !empty;

  assign top_data  = ent_q[top_q];
  assign top_valid = !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (do_swap) begin
      ent_q[top_q] <= push_data;
    end else if (do_push) begin
      top_q <= top_q + AW'(1);
      ent_q[top_q + AW'(1)] <= push_data;
      if (!full) cnt_q <= cnt_q + CW'(1);
    end else if (do_pop) begin
      top_q <= top_q - AW'(1);
      cnt_q <= cnt_q - CW'(1);
    end
  end

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && empty |=> empty);
  p_push_shows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top_valid && top_data == $past(push_data));
  p_swap_depth_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !empty |=> $stable(cnt_q));
endmodule

// File: rtl/bpred_spec_limit.sv
module bpred_spec_limit #(
  parameter int MAX_OUT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic retire,
  input  logic flush,
  output logic grant
);
  localparam int CW = $clog2(MAX_OUT + 1);

  logic [CW-1:0] cnt_q;
  logic          at_cap, add_one, sub_one;

  assign at_cap  = (cnt_q == CW'(MAX_OUT));
  assign grant   = req && !at_cap;
  assign add_one = grant;
  assign sub_one = retire && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) cnt_q <= '0;
    else if (add_one && !sub_one) cnt_q <= cnt_q + CW'(1);
    else if (sub_one && !add_one) cnt_q <= cnt_q - CW'(1);
  end

  p_cap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_OUT));
  p_no_grant_at_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    at_cap |-> !grant);
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == '0);
endmodule

// File: rtl/bpred_top.sv
module bpred_top
  import bpred_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int IDX_W    = 11,
  parameter int RS_DEPTH = 8,
  parameter int MAX_OUT  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dyn_en,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_backward,
  output logic            lk_taken,
  output logic            lk_grant,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            flush,
  input  logic            push_valid,
  input  logic [PC_W-1:0] push_addr,
  input  logic            pop_valid,
  output logic [PC_W-1:0] ret_target,
  output logic            ret_valid
);
  ctr_t lk_ctr;

  bpred_ctr_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .rd_pc(lk_pc), .rd_ctr(lk_ctr),
    .wr_en(up_valid), .wr_pc(up_pc), .wr_taken(up_taken));

  bpred_ret_stack #(.W(PC_W), .DEPTH(RS_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_valid), .push_data(push_addr),
    .pop(pop_valid), .top_data(ret_target), .top_valid(ret_valid));

  bpred_spec_limit #(.MAX_OUT(MAX_OUT)) u_limit (
    .clk(clk), .rst_n(rst_n), .req(lk_valid), .retire(up_valid),
    .flush(flush), .grant(lk_grant));

  assign lk_taken = dyn_en ? ctr_taken(lk_ctr) : lk_backward;

  p_static_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dyn_en |-> lk_taken == lk_backward);
endmodule

// File: tb/bpred_top_tb.sv
module bpred_top_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, dyn_en, lk_valid, lk_backward, up_valid, up_taken;
  logic flush, push_valid, pop_valid, lk_taken, lk_grant, ret_valid;
  logic [31:0] lk_pc, up_pc, push_addr, ret_target;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bpred_top u_dut (.*);

  // {up_taken, expected prediction after the update}, from weakly not-taken
  localparam logic [1:0] VEC [8] = '{2'b11, 2'b11, 2'b11, 2'b01,
                                     2'b00, 2'b00, 2'b00, 2'b10};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_backward = 0; up_valid = 0; up_taken = 0; flush = 0;
    push_valid = 0; pop_valid = 0;
  endtask

  task automatic step();   // move to next negedge, clear pulses
    @(negedge clk); idle(); #1;
  endtask

  task automatic upd(logic [31:0] pc, logic t);
    up_valid = 1; up_pc = pc; up_taken = t; step();
  endtask

  task automatic look(logic [31:0] pc);   // combinational lookup, no clock
    lk_pc = pc; #1;
  endtask

  task automatic push(logic [31:0] a);
    push_valid = 1; push_addr = a; step();
  endtask

  task automatic pop();
    pop_valid = 1; step();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(); dyn_en = 1; lk_pc = 0; up_pc = 0; push_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;

    // R1 reset state
    look(32'h1000); chk("R1 counter weakly not-taken", lk_taken, 0);
    chk("R1 stack empty", ret_valid, 0);
    lk_valid = 1; #1; chk("R1 count zero grants", lk_grant, 1);
    lk_valid = 0; #1;

    // R3 R4 vector walk on one counter
    foreach (VEC[i]) begin
      upd(32'h0000_2000, VEC[i][1]);
      look(32'h0000_2000);
      chk($sformatf("R4/R3 vec%0d", i), lk_taken, VEC[i][0]);
    end
    flush = 1; step();

    // R2 index bits [12:2]
    upd(32'h1000, 1); upd(32'h1000, 1);
    look(32'h0000_3000 | 32'h1000); chk("R2 bit13 aliases", lk_taken, 1);
    look(32'hFFFF_E003 & 32'hFFFF_F003 | 32'h1000); chk("R2 upper/low bits alias", lk_taken, 1);
    look(32'h1004); chk("R2 neighbour separate", lk_taken, 0);

    // R5 static mode
    dyn_en = 0; lk_backward = 1; look(32'h1004); chk("R5 backward taken", lk_taken, 1);
    lk_backward = 0; look(32'h1000); chk("R5 forward not-taken", lk_taken, 0);
    dyn_en = 1; look(32'h1000); chk("R5 dynamic restored", lk_taken, 1);
    flush = 1; step();

    // R6 cap at three
    for (int k = 0; k < 3; k++) begin
      lk_valid = 1; #1; chk($sformatf("R6 grant %0d", k), lk_grant, 1); step();
    end
    lk_valid = 1; #1; chk("R6 fourth stalls", lk_grant, 0);
    up_valid = 1; up_pc = 32'h8000; #1; chk("R6 stall through resolve cycle", lk_grant, 0);
    step();
    lk_valid = 1; #1; chk("R7 resolve frees slot", lk_grant, 1); step();
    lk_valid = 1; #1; chk("R6 full again", lk_grant, 0);
    lk_valid = 0; flush = 1; step();
    lk_valid = 1; #1; chk("R7 flush clears", lk_grant, 1); lk_valid = 0;
    // flush wins over a same-cycle lookup
    lk_valid = 1; flush = 1; step();
    // R7 resolve at zero does not underflow
    upd(32'h8000, 0); upd(32'h8000, 0);
    for (int k = 0; k < 3; k++) begin
      lk_valid = 1; #1; chk($sformatf("R7 no underflow grant %0d", k), lk_grant, 1); step();
    end
    lk_valid = 1; #1; chk("R7 fourth after underflow attempt", lk_grant, 0);
    lk_valid = 0; flush = 1; step();

    // R8 LIFO
    push(32'hA0); push(32'hB0);
    chk("R8 top is last push", ret_target, 32'hB0);
    pop(); chk("R8 pop exposes below", ret_target, 32'hA0); chk("R8 valid", ret_valid, 1);
    pop(); chk("R8 empty after pops", ret_valid, 0);

    // R10 pop on empty
    pop(); chk("R10 still empty", ret_valid, 0);
    push(32'hC0); chk("R10 push after empty pop", ret_target, 32'hC0);
    pop(); chk("R10 depth not corrupted", ret_valid, 0);

    // R9 overflow overwrites oldest
    for (int k = 1; k <= 9; k++) push(32'h100 + k);
    for (int k = 9; k >= 2; k--) begin
      chk($sformatf("R9 drain %0d", k), ret_target, 32'h100 + k);
      chk("R9 valid while draining", ret_valid, 1);
      pop();
    end
    chk("R9 oldest dropped", ret_valid, 0);

    // R11 push+pop replaces top
    push(32'hD0); push(32'hE0);
    push_valid = 1; push_addr = 32'hF0; pop_valid = 1; step();
    chk("R11 replaced top", ret_target, 32'hF0);
    pop(); chk("R11 depth kept", ret_target, 32'hD0);
    pop(); chk("R11 empty", ret_valid, 0);
    push_valid = 1; push_addr = 32'h77; pop_valid = 1; step();
    chk("R11 pair on empty pushes", ret_target, 32'h77); chk("R11 valid", ret_valid, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule